// File: doc/BRIEF.md
# Forwarded Write Local Port

This block sits on the local side of a bus bridge. It takes single-cycle writes that the upstream bus forwards and hands each one to a local agent. Each accepted upstream transfer leaves its address in an address register. When that address lies inside one of the configured forwarding windows, the write data and byte enables are also captured. The block then raises an active-low attention flag together with the window number and a write-direction flag.

The local agent reads the captured data, and if it needs it the captured address, through a small register port. The port uses a select strobe, a read strobe and a register offset. The agent may keep the read strobe asserted for as long as it needs. It closes the transfer by pulling its ready input low. Only then does the upstream side see completion, and only then is a new transfer accepted.

In 16-bit local mode, one local address bit chooses which half of the selected register appears on the low data lanes.

Top module: `fwd_write_port`

## Requirements
- R1: After reset, lo_attn_n is 1, up_ready is 1, up_done is 0, lo_dq_oe is 0, lo_win is 0, lo_wr is 0 and lo_be_n is all ones.
- R2: An upstream start taken while up_ready is 1 stores up_addr in the address register, whether or not the address hits a window. The stored address reads back at offset ADDR_OFS (default 5'h07).
- R3: The address hits window k when its bits [AW-1:WIN_SHIFT] equal those of base k. With the defaults, base k is 0x4000_0000 + k*0x1000_0000 and WIN_SHIFT is 12. On a hit the write data is captured; it reads back at offset DATA_OFS (default 5'h0B). A miss leaves the data register unchanged and raises no attention. The lowest-numbered window wins when windows overlap.
- R4: On the clock edge that takes a hitting start, lo_attn_n goes to 0 and stays there. While it is 0, lo_win carries the window number, lo_wr is 1 and lo_be_n carries the captured byte enables. While it is 1, lo_win is 0, lo_wr is 0 and lo_be_n is all ones.
- R5: lo_dq_oe is 1 only when lo_sel_n and lo_rd_n are both 0 and lo_ofs equals DATA_OFS or ADDR_OFS. While lo_dq_oe is 0, lo_dq is all zeros.
- R6: The captured data stays unchanged on lo_dq for as long as the read strobe is held, until lo_ready_n is sampled low.
- R7: If lo_ready_n is sampled low while lo_attn_n is 0, then on that edge lo_attn_n returns to 1 and up_ready returns to 1. up_done is 1 for exactly the following cycle. lo_ready_n has no effect while lo_attn_n is 1.
- R8: While up_ready is 0, an upstream start is ignored and changes neither the address nor the data register. This includes a start in the same cycle that lo_ready_n is sampled low.
- R9: When lo_mode16 is 1, lo_dq[15:0] carries the lower half of the selected register if lo_adr1 is 0 and the upper half if lo_adr1 is 1, and lo_dq[31:16] is 0. When lo_mode16 is 0, lo_dq carries the full register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; all inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_start | input | 1 | Upstream transfer strobe, one cycle |
| up_addr | input | AW | Upstream address |
| up_wdata | input | DW | Upstream write data |
| up_be_n | input | BW | Upstream byte enables, active low |
| up_ready | output | 1 | High when a new transfer can be accepted |
| up_done | output | 1 | One-cycle completion pulse for the forwarded write |
| lo_mode16 | input | 1 | Selects the 16-bit local data mode |
| lo_sel_n | input | 1 | Local register select, active low |
| lo_rd_n | input | 1 | Local read strobe, active low |
| lo_ofs | input | 5 | Local register offset (word address) |
| lo_adr1 | input | 1 | Half-word select in 16-bit mode |
| lo_ready_n | input | 1 | Local agent finished, active low |
| lo_attn_n | output | 1 | Forwarded write pending, active low |
| lo_win | output | WNW | Window number of the pending write |
| lo_wr | output | 1 | Direction flag, 1 for a forwarded write |
| lo_be_n | output | BW | Byte enables of the pending write, active low |
| lo_dq | output | DW | Local read data |
| lo_dq_oe | output | 1 | Local data bus drive enable |

## Verification
The local agent's ready and a new upstream start can arrive in the same cycle. The start must be refused, because the block is still busy at that edge. The bench provokes this at random after some transfers by raising up_start with a fresh address in the same cycle as lo_ready_n. After the completion pulse, it judges the result by reading the address and data registers back: both must still hold the earlier transfer's values. Long read strobes during the pending window are also checked every cycle for unchanged data.

// File: rtl/fwd_write_port.sv
module fwd_write_port #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NWIN = 4,
  parameter int WIN_SHIFT = 12,
  parameter logic [NWIN*AW-1:0] WIN_BASE =
    {32'h7000_0000, 32'h6000_0000, 32'h5000_0000, 32'h4000_0000},
  parameter logic [4:0] DATA_OFS = 5'h0B,
  parameter logic [4:0] ADDR_OFS = 5'h07,
  localparam int BW = DW / 8,
  localparam int WNW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           up_start,
  input  logic [AW-1:0]  up_addr,
  input  logic [DW-1:0]  up_wdata,
  input  logic [BW-1:0]  up_be_n,
  output logic           up_ready,
  output logic           up_done,
  input  logic           lo_mode16,
  input  logic           lo_sel_n,
  input  logic           lo_rd_n,
  input  logic [4:0]     lo_ofs,
  input  logic           lo_adr1,
  input  logic           lo_ready_n,
  output logic           lo_attn_n,
  output logic [WNW-1:0] lo_win,
  output logic           lo_wr,
  output logic [BW-1:0]  lo_be_n,
  output logic [DW-1:0]  lo_dq,
  output logic           lo_dq_oe
);

  localparam int HW = DW / 2;
  localparam int TW = AW - WIN_SHIFT;

  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;
  logic [BW-1:0]   be_q;
  logic [WNW-1:0]  win_q;
  logic            busy_q, done_q;
  logic [NWIN-1:0] hit_vec;
  logic            hit_any;
  logic [WNW-1:0]  hit_idx;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign hit_vec[g] = up_addr[AW-1:WIN_SHIFT] == WIN_BASE[g*AW+WIN_SHIFT +: TW];
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = NWIN-1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_any = 1'b1;
        hit_idx = WNW'(i);
      end
    end
  end

  wire accept = up_start & ~busy_q;
  wire finish = busy_q & ~lo_ready_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '1;
      win_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) busy_q <= 1'b0;
      if (accept) begin
        addr_q <= up_addr;
        if (hit_any) begin
          data_q <= up_wdata;
          be_q   <= up_be_n;
          win_q  <= hit_idx;
          busy_q <= 1'b1;
        end
      end
    end
  end

  assign up_ready  = ~busy_q;
  assign up_done   = done_q;
  assign lo_attn_n = ~busy_q;
  assign lo_wr     = busy_q;
  assign lo_win    = busy_q ? win_q : '0;
  assign lo_be_n   = busy_q ? be_q : '1;

  wire rd_act = ~lo_sel_n & ~lo_rd_n;
  wire pick_d = lo_ofs == DATA_OFS;
  wire pick_a = lo_ofs == ADDR_OFS;

  logic [DW-1:0] word, out16;
  assign word  = pick_d ? data_q : DW'(addr_q);
  assign out16 = {{(DW-HW){1'b0}}, (lo_adr1 ? word[DW-1:HW] : word[HW-1:0])};

  assign lo_dq_oe = rd_act & (pick_d | pick_a);
  assign lo_dq    = !lo_dq_oe ? '0 : (lo_mode16 ? out16 : word);

  a_r4_attn_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lo_attn_n) |-> $past(up_start && up_ready));
  a_r5_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
    lo_dq_oe |-> (!lo_sel_n && !lo_rd_n));
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_attn_n && $past(!lo_attn_n)) |-> $stable(data_q));
  a_r7_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    up_done |-> $past(!lo_ready_n && !lo_attn_n));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    up_done |=> !up_done);
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_ready && $past(!up_ready)) |-> $stable(addr_q));

endmodule

// File: tb/fwd_write_port_bench.sv
`timescale 1ns/1ps
module fwd_write_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_start = 1'b0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic [3:0] up_be_n = '1;
  logic up_ready, up_done;
  logic lo_mode16 = 1'b0, lo_sel_n = 1'b1, lo_rd_n = 1'b1, lo_adr1 = 1'b0, lo_ready_n = 1'b1;
  logic [4:0] lo_ofs = '0;
  logic lo_attn_n, lo_wr, lo_dq_oe;
  logic [1:0] lo_win;
  logic [3:0] lo_be_n;
  logic [31:0] lo_dq;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] m_addr = '0, m_data = '0;

  always #2 clk = ~clk;

  fwd_write_port u_fwd_write_port (.*);

  function automatic logic [31:0] exp_rd(logic [31:0] w, logic m16, logic a1);
    if (!m16) return w;
    return a1 ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  function automatic bit exp_hit(logic [31:0] a);
    return a[31:28] >= 4'h4 && a[31:28] <= 4'h7 && a[27:12] == 16'h0;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(logic [4:0] ofs, logic [31:0] w, string req);
    logic m16 = 1'($urandom);
    logic a1 = 1'($urandom);
    @(negedge clk);
    lo_sel_n = 0; lo_rd_n = 0; lo_ofs = ofs; lo_mode16 = m16; lo_adr1 = a1;
    #1;
    chk(lo_dq_oe == 1, "R5", 32'(lo_dq_oe), 1);
    chk(lo_dq == exp_rd(w, m16, a1), req, lo_dq, exp_rd(w, m16, a1));
    lo_sel_n = 1; lo_rd_n = 1;
  endtask

  task automatic start(logic [31:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    up_start = 1; up_addr = a; up_wdata = d; up_be_n = be;
    @(negedge clk);
    up_start = 0;
    #1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk(lo_attn_n == 1 && up_ready == 1 && up_done == 0 && lo_dq_oe == 0, "R1",
        {lo_attn_n, up_ready, up_done, lo_dq_oe}, 4'b1100);
    chk(lo_win == 0 && lo_wr == 0 && lo_be_n == 4'hF, "R1", {lo_win, lo_wr, lo_be_n}, 7'h0F);
    rst_n = 1;

    // directed: 16-bit halves of address register
    start(32'h1234_5678, 32'hDEAD_BEEF, 4'h0);
    m_addr = 32'h1234_5678;
    @(negedge clk);
    lo_sel_n = 0; lo_rd_n = 0; lo_ofs = 5'h07; lo_mode16 = 1; lo_adr1 = 0; #1;
    chk(lo_dq == 32'h0000_5678, "R9", lo_dq, 32'h5678);
    lo_adr1 = 1; #1;
    chk(lo_dq == 32'h0000_1234, "R9", lo_dq, 32'h1234);
    lo_ofs = 5'h08; #1;
    chk(lo_dq_oe == 0 && lo_dq == 0, "R5", lo_dq, 0);
    lo_ofs = 5'h07; lo_sel_n = 1; #1;
    chk(lo_dq_oe == 0 && lo_dq == 0, "R5", lo_dq, 0);
    lo_rd_n = 1; lo_mode16 = 0;

    for (int it = 0; it < 300; it++) begin
      bit hit = ($urandom % 3) != 0;
      int k = $urandom % 4;
      logic [31:0] a = hit ? (32'h4000_0000 + 32'(k) * 32'h1000_0000 + ($urandom & 32'hFFF))
                           : ($urandom & 32'h3FFF_FFFF);
      logic [31:0] d = $urandom;
      logic [3:0] be = 4'($urandom);
      hit = exp_hit(a);
      k = a[29:28];
      start(a, d, be);
      m_addr = a;
      if (hit) m_data = d;
      chk(lo_attn_n == !hit, "R4", 32'(lo_attn_n), 32'(!hit));
      chk(up_ready == !hit, "R7", 32'(up_ready), 32'(!hit));
      rd_chk(5'h07, m_addr, "R2");
      if (hit) begin
        chk(lo_win == 2'(k) && lo_wr == 1 && lo_be_n == be, "R4",
            {lo_win, lo_wr, lo_be_n}, {2'(k), 1'b1, be});
        @(negedge clk);
        lo_sel_n = 0; lo_rd_n = 0; lo_ofs = 5'h0B; lo_mode16 = 1'($urandom); lo_adr1 = 1'($urandom);
        for (int c = 0; c < 1 + ($urandom % 6); c++) begin
          @(negedge clk); #1;
          chk(lo_dq == exp_rd(m_data, lo_mode16, lo_adr1), "R6", lo_dq,
              exp_rd(m_data, lo_mode16, lo_adr1));
        end
        lo_sel_n = 1; lo_rd_n = 1;
        if ($urandom % 2) begin
          start(32'h4000_0000 ^ m_addr, ~m_data, 4'h0);
          rd_chk(5'h07, m_addr, "R8");
        end
        repeat ($urandom % 3) @(negedge clk);
        @(negedge clk);
        lo_ready_n = 0;
        if ($urandom % 2) begin
          up_start = 1; up_addr = 32'h4000_0000 + ($urandom & 32'hFFF); up_wdata = ~m_data;
        end
        @(negedge clk);
        lo_ready_n = 1; up_start = 0; #1;
        chk(up_done == 1 && lo_attn_n == 1 && up_ready == 1, "R7",
            {up_done, lo_attn_n, up_ready}, 3'b111);
        chk(lo_win == 0 && lo_wr == 0 && lo_be_n == 4'hF, "R4", {lo_win, lo_wr, lo_be_n}, 7'h0F);
        @(negedge clk); #1;
        chk(up_done == 0, "R7", 32'(up_done), 0);
        rd_chk(5'h07, m_addr, "R8");
        rd_chk(5'h0B, m_data, "R8");
      end else begin
        rd_chk(5'h0B, m_data, "R3");
        @(negedge clk);
        lo_ready_n = 0;
        @(negedge clk);
        lo_ready_n = 1; #1;
        chk(up_done == 0 && lo_attn_n == 1, "R7", {up_done, lo_attn_n}, 2'b01);
      end
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act %h exp %h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule